// File: doc/BRIEF.md
# T1 Digital-Multiplexer Channel-24 Pattern Checker

This block watches a T1 stream that uses the digital-multiplexer framing variant. In that variant the last timeslot of every frame carries a fixed in-band octet. The block collects that octet bit by bit, with the most significant bit first, and compares its six defined bits with the fixed value. The two don't-care positions are ignored. Any mismatch gives one error pulse, which goes to a performance counter elsewhere on the chip.

The six defined bits, together with the framing bit that arrives next, form a seven-bit sync check. A superframe position counter supplies the expected framing bit. A failed seven-bit check is recorded in a short history. When the number of failures in a selectable window reaches the limit, the block pulses loss-of-sync and, if automatic reframing is enabled, asks the framer to search again. A rising edge on the manual trigger also asks for a reframe. While the framer reports that it is out of sync, all detection is suspended and every output stays low.

Top module: `t1dm_dds_chk`

## Requirements
- R1: After reset, `dds_err_o`, `chk7_err_o`, `sync_loss_o` and `reframe_o` are all low.
- R2: The octet is assembled from eight consecutive bit strobes with `ch24_i` high, and the first bit received is bit 7. One cycle after the eighth strobe, `dds_err_o` pulses for exactly one cycle if bit 7 is not 0 or bits 4..0 are not 11101.
- R3: Bits 6 and 5 of the octet never affect `dds_err_o` or `chk7_err_o`.
- R4: `sf_start_i`, given with a framing-bit strobe, marks frame 1. Each later framing strobe advances the position modulo 12. The expected framing bits for frames 1 to 12 are 1,0,0,0,1,1,0,1,1,1,0,0.
- R5: One cycle after the first framing-bit strobe that follows a completed octet, `chk7_err_o` pulses if any defined octet bit or that framing bit mismatches. There is at most one seven-bit check per octet.
- R6: Each seven-bit check adds one entry to a history. `ratio_sel_i` = 0, 1 or 2 selects a window of the last 4, 5 or 6 checks, and 3 disables the decision. When the window holds 2 or more failures, `sync_loss_o` pulses one cycle after that check and the history is cleared.
- R7: When `auto_en_i` is high, a loss-of-sync pulse is accompanied by a `reframe_o` pulse in the same cycle. When `auto_en_i` is low, no reframe is requested.
- R8: A 0-to-1 transition of `man_reframe_i` gives a one-cycle `reframe_o` pulse in the next cycle, whatever the value of `auto_en_i`.
- R9: While `in_sync_i` is low, all outputs are low one cycle later, and the partial octet, the pending check and the history are discarded.
- R10: Cycles with `bit_en_i` low advance no octet bit, no check and no history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One received bit is valid this cycle |
| data_i | input | 1 | Received serial bit |
| ch24_i | input | 1 | Current bit belongs to timeslot 24 |
| fbit_i | input | 1 | Current bit is the framing bit |
| sf_start_i | input | 1 | Framing bit of superframe frame 1 |
| in_sync_i | input | 1 | Framer is in frame alignment |
| ratio_sel_i | input | 2 | Loss-of-sync window select |
| auto_en_i | input | 1 | Allow automatic reframe on loss of sync |
| man_reframe_i | input | 1 | Manual reframe trigger, rising edge |
| dds_err_o | output | 1 | Channel-24 pattern error pulse |
| chk7_err_o | output | 1 | Seven-bit sync check failure pulse |
| sync_loss_o | output | 1 | Loss-of-sync decision pulse |
| reframe_o | output | 1 | Reframe request pulse |

## Verification
A bit counter that slips moves the octet boundary, so an otherwise clean stream shows a `dds_err_o` pulse within the first frame. A superframe position that is off by one shows spurious `chk7_err_o` pulses within a few frames, because the expected framing sequence is not periodic over short spans. A history that is not cleared, or a window of the wrong length, moves `sync_loss_o` by one check. This is caught when two failures are spaced exactly at the window length or one check inside it. State left over from an out-of-sync period shows as a check or loss pulse on the first framing strobe after re-sync.

// File: rtl/t1dm_pkg.sv
package t1dm_pkg;
  localparam int unsigned OCT_W  = 8;
  localparam int unsigned SF_LEN = 12;
  // defined bits of the channel-24 octet, MSB received first
  localparam logic [OCT_W-1:0] DDS_MASK = 8'b1001_1111;
  localparam logic [OCT_W-1:0] DDS_VAL  = 8'b0001_1101;
  // expected framing bit, bit i = frame i+1 of the superframe
  localparam logic [SF_LEN-1:0] F_SEQ = 12'b0011_1011_0001;

  typedef enum logic [1:0] {
    RATIO_W4  = 2'd0,
    RATIO_W5  = 2'd1,
    RATIO_W6  = 2'd2,
    RATIO_OFF = 2'd3
  } ratio_e;
endpackage

// File: rtl/t1dm_octet_cmp.sv
module t1dm_octet_cmp #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] VAL  = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bit_en_i,
  input  logic ch24_i,
  input  logic data_i,
  output logic done_o,
  output logic mism_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-2:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  full;

  assign full = {sh_q, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
      mism_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
      mism_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (bit_en_i) begin
        if (!ch24_i) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(W-1)) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
          mism_o <= ((full & MASK) != VAL);
        end else begin
          sh_q  <= full[W-2:0];
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/t1dm_fpos.sv
module t1dm_fpos #(
  parameter int unsigned SF_LEN = 12,
  parameter logic [SF_LEN-1:0] SEQ = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic fbit_i,
  input  logic sf_start_i,
  output logic exp_o
);
  localparam int unsigned PW = $clog2(SF_LEN);

  logic [PW-1:0] pos_q, pos_nxt;

  always_comb begin
    if (sf_start_i)                        pos_nxt = '0;
    else if (pos_q == PW'(SF_LEN-1))       pos_nxt = '0;
    else                                   pos_nxt = pos_q + 1'b1;
  end

  // expected value of the framing bit being received now
  assign exp_o = SEQ[pos_nxt];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pos_q <= '0;
    else if (bit_en_i && fbit_i)    pos_q <= pos_nxt;
  end
endmodule

// File: rtl/t1dm_ratio_mon.sv
module t1dm_ratio_mon #(
  parameter int unsigned HIST_MAX = 6,
  parameter int unsigned LOSS_CNT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       push_i,
  input  logic       err_i,
  input  logic [1:0] sel_i,
  output logic       trip_o
);
  import t1dm_pkg::*;
  localparam int unsigned CW = $clog2(HIST_MAX + 1);

  logic [HIST_MAX-1:0] hist_q, hist_nxt;
  logic [CW-1:0]       cnt;
  int unsigned         win;

  assign hist_nxt = {hist_q[HIST_MAX-2:0], err_i};
  // selects 0..2 give windows HIST_MAX-2 .. HIST_MAX
  assign win = HIST_MAX - 2 + int'(sel_i);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < HIST_MAX; i++)
      if (i < win) cnt = cnt + CW'(hist_nxt[i]);
  end

  assign trip_o = push_i && (ratio_e'(sel_i) != RATIO_OFF) && (cnt >= CW'(LOSS_CNT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (clr_i)   hist_q <= '0;
    else if (push_i)  hist_q <= trip_o ? '0 : hist_nxt;
  end
endmodule

// File: rtl/t1dm_dds_chk.sv
module t1dm_dds_chk
  import t1dm_pkg::*;
#(
  parameter int unsigned HIST_MAX = 6,
  parameter int unsigned LOSS_CNT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       data_i,
  input  logic       ch24_i,
  input  logic       fbit_i,
  input  logic       sf_start_i,
  input  logic       in_sync_i,
  input  logic [1:0] ratio_sel_i,
  input  logic       auto_en_i,
  input  logic       man_reframe_i,
  output logic       dds_err_o,
  output logic       chk7_err_o,
  output logic       sync_loss_o,
  output logic       reframe_o
);
  logic clr;
  logic oct_done, oct_mism, exp_f, trip;
  logic pend_q, perr_q, man_q;
  logic have_oct, oct_err, fire, err7, man_rise;

  assign clr = !in_sync_i;

  t1dm_octet_cmp #(.W(OCT_W), .MASK(DDS_MASK), .VAL(DDS_VAL)) u_oct (
    .clk_i, .rst_ni, .clr_i(clr), .bit_en_i, .ch24_i, .data_i,
    .done_o(oct_done), .mism_o(oct_mism)
  );

  t1dm_fpos #(.SF_LEN(SF_LEN), .SEQ(F_SEQ)) u_fpos (
    .clk_i, .rst_ni, .bit_en_i, .fbit_i, .sf_start_i, .exp_o(exp_f)
  );

  // an octet finished last cycle is usable before it lands in pend_q
  assign have_oct = pend_q || oct_done;
  assign oct_err  = oct_done ? oct_mism : perr_q;
  assign fire     = in_sync_i && bit_en_i && fbit_i && have_oct;
  assign err7     = oct_err || (data_i != exp_f);
  assign man_rise = man_reframe_i && !man_q;

  t1dm_ratio_mon #(.HIST_MAX(HIST_MAX), .LOSS_CNT(LOSS_CNT)) u_ratio (
    .clk_i, .rst_ni, .clr_i(clr), .push_i(fire), .err_i(err7),
    .sel_i(ratio_sel_i), .trip_o(trip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      perr_q      <= 1'b0;
      man_q       <= 1'b0;
      chk7_err_o  <= 1'b0;
      sync_loss_o <= 1'b0;
      reframe_o   <= 1'b0;
    end else begin
      man_q <= man_reframe_i;
      if (clr) begin
        pend_q      <= 1'b0;
        perr_q      <= 1'b0;
        chk7_err_o  <= 1'b0;
        sync_loss_o <= 1'b0;
        reframe_o   <= 1'b0;
      end else begin
        chk7_err_o  <= fire && err7;
        sync_loss_o <= trip;
        reframe_o   <= (trip && auto_en_i) || man_rise;
        if (fire) begin
          pend_q <= 1'b0;
        end else if (oct_done) begin
          pend_q <= 1'b1;
          perr_q <= oct_mism;
        end
      end
    end
  end

  assign dds_err_o = oct_done && oct_mism;
endmodule

// File: rtl/t1dm_dds_chk_sva.sv
module t1dm_dds_chk_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       ch24_i,
  input logic       fbit_i,
  input logic       in_sync_i,
  input logic       auto_en_i,
  input logic       dds_err_o,
  input logic       chk7_err_o,
  input logic       sync_loss_o,
  input logic       reframe_o
);
  // R2
  dds_after_ch24_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dds_err_o |-> $past(bit_en_i && ch24_i));

  // R5
  chk7_after_fbit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk7_err_o |-> $past(bit_en_i && fbit_i && in_sync_i));

  // R6
  loss_on_check_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_loss_o |-> $past(bit_en_i && fbit_i));

  // R7
  auto_reframe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_loss_o && $past(auto_en_i)) |-> reframe_o);

  // R9
  quiet_out_of_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_sync_i |=> !(dds_err_o || chk7_err_o || sync_loss_o || reframe_o));

  // R10
  idle_no_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> !(dds_err_o || chk7_err_o || sync_loss_o));
endmodule

bind t1dm_dds_chk t1dm_dds_chk_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .ch24_i(ch24_i),
  .fbit_i(fbit_i), .in_sync_i(in_sync_i), .auto_en_i(auto_en_i),
  .dds_err_o(dds_err_o), .chk7_err_o(chk7_err_o),
  .sync_loss_o(sync_loss_o), .reframe_o(reframe_o)
);

// File: tb/t1dm_dds_chk_bench.sv
module t1dm_dds_chk_bench;
  localparam logic [7:0]  GOOD = 8'b0001_1101;
  localparam logic [11:0] F_TB = 12'b0011_1011_0001; // R4 sequence, bit i = frame i+1

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic bit_en = 0, data = 0, ch24 = 0, fbit = 0, sfs = 0;
  logic insync = 0, auto = 0, man = 0;
  logic [1:0] sel = 2'd0;
  logic dds, chk7, loss, refr;

  t1dm_dds_chk u_t1dm_dds_chk (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .data_i(data), .ch24_i(ch24),
    .fbit_i(fbit), .sf_start_i(sfs), .in_sync_i(insync), .ratio_sel_i(sel),
    .auto_en_i(auto), .man_reframe_i(man), .dds_err_o(dds), .chk7_err_o(chk7),
    .sync_loss_o(loss), .reframe_o(refr)
  );

  int n_chk = 0, n_fail = 0, tb_fr = 0;
  string phase = "R1";

  // reference state
  int m_cnt = 0, m_pos = 0;
  logic [7:0] m_oct = '0;
  logic m_pend = 0, m_perr = 0, m_manq = 0;
  logic [5:0] m_hist = '0;

  task automatic chk1(string nm, string rq, logic a, logic e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s [%s] %s actual=%0b expected=%0b t=%0t", rq, phase, nm, a, e, $time);
    end
  endtask

  task automatic step(logic be, logic d, logic ch, logic fb, logic sf);
    logic e_dds, e_chk, e_loss, e_ref, err, trip;
    logic [5:0] nh;
    logic [7:0] full;
    int np, c;
    @(negedge clk);
    bit_en = be; data = d; ch24 = ch; fbit = fb; sfs = sf;
    @(posedge clk);
    e_dds = 0; e_chk = 0; e_loss = 0; e_ref = 0;
    np = sf ? 0 : ((m_pos == 11) ? 0 : m_pos + 1);
    if (!insync) begin
      m_cnt = 0; m_pend = 0; m_hist = '0;
    end else begin
      if (be) begin
        if (!ch) m_cnt = 0;
        else if (m_cnt == 7) begin
          full = {m_oct[6:0], d};
          e_dds = ((full & 8'b1001_1111) != GOOD);
          m_pend = 1; m_perr = e_dds; m_cnt = 0;
        end else begin
          m_oct = {m_oct[6:0], d}; m_cnt++;
        end
        if (fb && m_pend) begin
          err = m_perr | (d != F_TB[np]);
          e_chk = err;
          nh = {m_hist[4:0], err};
          c = 0;
          for (int i = 0; i < 4 + int'(sel); i++) c += int'(nh[i]);
          trip = (sel != 2'd3) && (c >= 2);
          m_hist = trip ? '0 : nh;
          e_loss = trip;
          m_pend = 0;
        end
      end
      e_ref = (e_loss && auto) || (man && !m_manq);
    end
    m_manq = man;
    if (be && fb) m_pos = np;
    #2;
    chk1("dds_err_o",   "R2", dds,  e_dds);
    chk1("chk7_err_o",  "R5", chk7, e_chk);
    chk1("sync_loss_o", "R6", loss, e_loss);
    chk1("reframe_o",   "R7", refr, e_ref);
  endtask

  // framing bit, two filler bits, optional gaps, then the channel-24 octet
  task automatic send_frame(logic [7:0] oct, logic fflip, int gap);
    step(1, F_TB[tb_fr] ^ fflip, 0, 1, tb_fr == 0);
    tb_fr = (tb_fr + 1) % 12;
    repeat (2) step(1, 1'($urandom), 0, 0, 0);
    for (int b = 7; b >= 0; b--) begin
      step(1, oct[b], 1, 0, 0);
      for (int g = 0; g < gap; g++) step(0, 1'($urandom), 1, 0, 0); // R10 gaps
    end
  endtask

  function automatic logic [7:0] bad(int b);
    return GOOD ^ (8'h01 << b);
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int defb[6];
    defb = '{7, 4, 3, 2, 1, 0};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk1("dds_err_o", "R1", dds, 0);
    chk1("chk7_err_o", "R1", chk7, 0);
    chk1("sync_loss_o", "R1", loss, 0);
    chk1("reframe_o", "R1", refr, 0);
    rst_n = 1;
    insync = 1; sel = 2'd0; auto = 1;

    phase = "R4";
    for (int k = 0; k < 26; k++) send_frame(GOOD, 0, 0);

    phase = "R3";
    for (int k = 0; k < 16; k++) send_frame(GOOD | (8'($urandom) & 8'b0110_0000), 0, 0);

    phase = "R2";
    foreach (defb[j]) begin
      send_frame(bad(defb[j]), 0, 0);
      repeat (3) send_frame(GOOD, 0, 0);
    end

    phase = "R5";
    for (int k = 0; k < 6; k++) begin
      send_frame(GOOD, 0, 0);
      send_frame(GOOD, 1, 0);
      repeat (2) send_frame(GOOD, 0, 0);
    end

    phase = "R6";
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      for (int d = 2; d <= 7; d++) begin
        send_frame(bad(0), 0, 0);
        repeat (d - 1) send_frame(GOOD, 0, 0);
        send_frame(bad(7), 0, 0);
        repeat (7) send_frame(GOOD, 0, 0);
      end
    end

    phase = "R7";
    sel = 2'd0; auto = 0;
    repeat (3) send_frame(bad(2), 0, 0);
    repeat (3) send_frame(GOOD, 0, 0);
    auto = 1;

    phase = "R8";
    for (int k = 0; k < 3; k++) begin
      auto = 1'(k);
      man = 1; step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      man = 0; step(0, 0, 0, 0, 0);
    end

    phase = "R9";
    send_frame(GOOD, 0, 0);
    step(1, 1, 1, 0, 0); step(1, 0, 1, 0, 0);
    insync = 0;
    man = 1;
    send_frame(bad(4), 1, 0);
    send_frame(bad(3), 0, 0);
    man = 0;
    insync = 1;
    repeat (4) send_frame(GOOD, 0, 0);

    phase = "R10";
    for (int k = 0; k < 8; k++) send_frame((k % 3 == 0) ? bad(1) : GOOD, 0, 1 + k % 2);

    phase = "random";
    for (int k = 0; k < 300; k++) begin
      logic [7:0] o;
      if (k % 40 == 0) begin sel = 2'($urandom); auto = 1'($urandom); end
      o = GOOD | (8'($urandom) & 8'b0110_0000);
      if ($urandom_range(9) == 0) o = o ^ (8'h01 << defb[$urandom_range(5)]);
      man = ($urandom_range(19) == 0);
      insync = ($urandom_range(49) != 0);
      send_frame(o, $urandom_range(12) == 0, ($urandom_range(7) == 0) ? 1 : 0);
      if (!insync) begin insync = 1; end
    end
    man = 0;
    repeat (3) send_frame(GOOD, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule